// File: doc/BRIEF.md
# FEAC Codeword Validation Controller

This block sits behind the far-end alarm and control (FEAC) channel extractor of a DS3 receive framer running C-bit parity framing. The extractor hands it one 6-bit codeword per strobe. The block keeps a sliding window of the ten most recent codewords. It declares a codeword validated when that codeword dominates the window. It later withdraws the codeword when enough other codewords have arrived in the window.

Each of the two events, validation and removal, has a pending flag that stays set until a read clears it, and an enable bit that software can write. A single interrupt line is the OR of the pending flags whose enable bits are set. The validated codeword and its valid flag are visible on dedicated outputs. The controller does anything only while the framing mode input selects C-bit parity. In any other mode, strobes are dropped.

Top module: `feac_vote_ctrl`

## Requirements
- R1: After reset, `code_valid_o`, `code_o`, `reg_rdata_o` and `irq_o` are all 0, and the window is empty. A codeword therefore needs 8 strobes after reset before it can be validated.
- R2: When no codeword is validated, the block validates a codeword if, after a strobe is taken in, that 6-bit value fills at least 8 of the 10 window slots. `code_valid_o` goes to 1 and `code_o` shows the value in the cycle after the strobe is sampled. Seven copies are not enough.
- R3: A validated codeword is withdrawn (`code_valid_o` goes to 0) in the cycle after the strobe that leaves at least 3 of the 10 window slots holding a different value.
- R4: A validation sets the validate pending flag, register bit 0.
- R5: A removal sets the remove pending flag, register bit 2.
- R6: `reg_rdata_o` shows the current flags without delay. A pending flag stays set until a cycle with `reg_rd_i`=1, after which it is 0.
- R7: When a read and an event that sets a flag fall in the same cycle, that flag is 1 after the cycle.
- R8: `irq_o` = (bit3 AND bit2) OR (bit1 AND bit0) of the register. Clearing an enable bit masks its event's pending flag from the interrupt.
- R9: While `mode_cbit_i`=0, strobes are ignored: the window does not move, the validated codeword does not change, and no pending flag is set.
- R10: Register layout: bit3 = remove enable, bit2 = remove pending, bit1 = validate enable, bit0 = validate pending. A write (`reg_wr_i`=1) loads only bits 3 and 1 from `reg_wdata_i`. The pending bits cannot be written.
- R11: A removal does not clear the window. After a removal brought on by three copies of one value, five more copies of that value validate it, and four do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_cbit_i | input | 1 | 1 = DS3 C-bit parity framing, controller active |
| msg_valid_i | input | 1 | Codeword strobe |
| msg_code_i | input | 6 | Received FEAC codeword |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 4 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (clears pending flags) |
| reg_rdata_o | output | 4 | Register read data |
| code_valid_o | output | 1 | A validated codeword is held |
| code_o | output | 6 | Validated codeword |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every result of this block is due one clock after the edge that samples its cause. A strobe, read or write takes effect at one rising edge. `code_valid_o`, `code_o`, the pending and enable bits and `irq_o` then hold their new values before the next edge. `reg_rdata_o` is combinational from the registers, so a read returns the flags as they were before the clear. The bench drives inputs at the falling edge and updates its model just after the rising edge. It compares every output at the following falling edge, so each comparison falls exactly one edge after the stimulus.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int unsigned REG_W     = 4;
  localparam int unsigned BIT_RM_EN = 3;
  localparam int unsigned BIT_RM_ST = 2;
  localparam int unsigned BIT_VA_EN = 1;
  localparam int unsigned BIT_VA_ST = 0;

  typedef struct packed {
    logic va;
    logic rm;
  } feac_evt_t;
endpackage

// File: rtl/feac_history.sv
module feac_history #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned DEPTH  = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_i,
  input  logic [CODE_W-1:0]             code_i,
  output logic [DEPTH-1:0][CODE_W-1:0]  nxt_code_o,
  output logic [DEPTH-1:0]              nxt_vld_o
);
  logic [DEPTH-1:0][CODE_W-1:0] code_q;
  logic [DEPTH-1:0]             vld_q;

  // slot 0 is newest
  always_comb begin
    nxt_code_o[0] = shift_i ? code_i : code_q[0];
    nxt_vld_o[0]  = shift_i ? 1'b1   : vld_q[0];
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_slot
    always_comb begin
      nxt_code_o[k] = shift_i ? code_q[k-1] : code_q[k];
      nxt_vld_o[k]  = shift_i ? vld_q[k-1]  : vld_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      vld_q  <= '0;
    end else begin
      code_q <= nxt_code_o;
      vld_q  <= nxt_vld_o;
    end
  end
endmodule

// File: rtl/feac_vote.sv
module feac_vote #(
  parameter int unsigned CODE_W  = 6,
  parameter int unsigned DEPTH   = 10,
  parameter int unsigned VAL_MIN = 8,
  parameter int unsigned RM_MIN  = 3
) (
  input  logic [DEPTH-1:0][CODE_W-1:0] hist_code_i,
  input  logic [DEPTH-1:0]             hist_vld_i,
  input  logic                         cur_vld_i,
  input  logic [CODE_W-1:0]            cur_code_i,
  output logic                         val_hit_o,
  output logic [CODE_W-1:0]            val_code_o,
  output logic                         rm_hit_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] same_cnt [DEPTH];
  logic [DEPTH-1:0] slot_hit;
  logic [CNT_W-1:0] diff_cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cnt
    always_comb begin
      same_cnt[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (hist_vld_i[i] && hist_vld_i[j] && (hist_code_i[j] == hist_code_i[i]))
          same_cnt[i] = same_cnt[i] + CNT_W'(1);
      end
      slot_hit[i] = (same_cnt[i] >= CNT_W'(VAL_MIN));
    end
  end

  // all hitting slots carry the same value; take the newest
  always_comb begin
    val_code_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (slot_hit[i]) val_code_o = hist_code_i[i];
    end
    val_hit_o = !cur_vld_i && (|slot_hit);
  end

  always_comb begin
    diff_cnt = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (hist_vld_i[j] && (hist_code_i[j] != cur_code_i))
        diff_cnt = diff_cnt + CNT_W'(1);
    end
    rm_hit_o = cur_vld_i && (diff_cnt >= CNT_W'(RM_MIN));
  end
endmodule

// File: rtl/feac_irq_regs.sv
module feac_irq_regs
  import feac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  feac_evt_t        evt_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic va_en_q, rm_en_q, va_st_q, rm_st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_en_q <= 1'b0;
      rm_en_q <= 1'b0;
      va_st_q <= 1'b0;
      rm_st_q <= 1'b0;
    end else begin
      if (wr_i) begin
        va_en_q <= wdata_i[BIT_VA_EN];
        rm_en_q <= wdata_i[BIT_RM_EN];
      end
      // new event wins over a concurrent read
      va_st_q <= (va_st_q && !rd_i) || evt_i.va;
      rm_st_q <= (rm_st_q && !rd_i) || evt_i.rm;
    end
  end

  always_comb begin
    rdata_o            = '0;
    rdata_o[BIT_RM_EN] = rm_en_q;
    rdata_o[BIT_RM_ST] = rm_st_q;
    rdata_o[BIT_VA_EN] = va_en_q;
    rdata_o[BIT_VA_ST] = va_st_q;
    irq_o = (rm_en_q && rm_st_q) || (va_en_q && va_st_q);
  end
endmodule

// File: rtl/feac_vote_ctrl.sv
module feac_vote_ctrl
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W  = 6,
  parameter int unsigned DEPTH   = 10,
  parameter int unsigned VAL_MIN = 8,
  parameter int unsigned RM_MIN  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_cbit_i,
  input  logic              msg_valid_i,
  input  logic [CODE_W-1:0] msg_code_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              code_valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o
);
  logic                         take;
  logic [DEPTH-1:0][CODE_W-1:0] win_code;
  logic [DEPTH-1:0]             win_vld;
  logic                         val_hit, rm_hit;
  logic [CODE_W-1:0]            val_code;
  logic                         cur_vld_q;
  logic [CODE_W-1:0]            cur_code_q;
  feac_evt_t                    evt;

  assign take = mode_cbit_i && msg_valid_i;

  feac_history #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (take),
    .code_i     (msg_code_i),
    .nxt_code_o (win_code),
    .nxt_vld_o  (win_vld)
  );

  feac_vote #(
    .CODE_W(CODE_W), .DEPTH(DEPTH), .VAL_MIN(VAL_MIN), .RM_MIN(RM_MIN)
  ) u_vote (
    .hist_code_i (win_code),
    .hist_vld_i  (win_vld),
    .cur_vld_i   (cur_vld_q),
    .cur_code_i  (cur_code_q),
    .val_hit_o   (val_hit),
    .val_code_o  (val_code),
    .rm_hit_o    (rm_hit)
  );

  always_comb begin
    evt.va = take && val_hit;
    evt.rm = take && rm_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_vld_q  <= 1'b0;
      cur_code_q <= '0;
    end else if (evt.va) begin
      cur_vld_q  <= 1'b1;
      cur_code_q <= val_code;
    end else if (evt.rm) begin
      cur_vld_q  <= 1'b0;
    end
  end

  feac_irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .rd_i    (reg_rd_i),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );

  assign code_valid_o = cur_vld_q;
  assign code_o       = cur_code_q;
endmodule

// File: rtl/feac_vote_ctrl_chk.sv
module feac_vote_ctrl_chk #(
  parameter int unsigned CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_cbit_i,
  input logic              msg_valid_i,
  input logic              reg_rd_i,
  input logic [3:0]        reg_rdata_o,
  input logic              code_valid_o,
  input logic [CODE_W-1:0] code_o,
  input logic              irq_o
);
  AST_VALID_SETS_VA_ST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(code_valid_o) |-> reg_rdata_o[0]); // R4

  AST_REMOVE_SETS_RM_ST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(code_valid_o) |-> reg_rdata_o[2]); // R5

  AST_VA_ST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[0] && !reg_rd_i) |=> reg_rdata_o[0]); // R6

  AST_RM_ST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[2] && !reg_rd_i) |=> reg_rdata_o[2]); // R6

  AST_READ_CLEARS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && !msg_valid_i) |=> (!reg_rdata_o[0] && !reg_rdata_o[2])); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[3] && !reg_rdata_o[1]) |-> !irq_o); // R8

  AST_MODE_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_cbit_i |=> ($stable(code_valid_o) && $stable(code_o)
                      && !$rose(reg_rdata_o[0]) && !$rose(reg_rdata_o[2]))); // R9

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |=> (!code_valid_o || $stable(code_o))); // R2
endmodule

bind feac_vote_ctrl feac_vote_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_cbit_i  (mode_cbit_i),
  .msg_valid_i  (msg_valid_i),
  .reg_rd_i     (reg_rd_i),
  .reg_rdata_o  (reg_rdata_o),
  .code_valid_o (code_valid_o),
  .code_o       (code_o),
  .irq_o        (irq_o)
);

// File: tb/tb_feac_vote_ctrl.sv
module tb_feac_vote_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_cbit_i = 1'b1;
  logic       msg_valid_i = 1'b0;
  logic [5:0] msg_code_i = '0;
  logic       reg_wr_i = 1'b0;
  logic [3:0] reg_wdata_i = '0;
  logic       reg_rd_i = 1'b0;
  logic [3:0] reg_rdata_o;
  logic       code_valid_o;
  logic [5:0] code_o;
  logic       irq_o;

  always #5 clk_i = ~clk_i;

  feac_vote_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_cbit_i(mode_cbit_i),
    .msg_valid_i(msg_valid_i), .msg_code_i(msg_code_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rd_i(reg_rd_i),
    .reg_rdata_o(reg_rdata_o), .code_valid_o(code_valid_o),
    .code_o(code_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model
  logic [5:0] m_hc [10];
  logic       m_hv [10];
  logic       m_vld = 0;
  logic [5:0] m_code = 0;
  logic       m_va_en = 0, m_rm_en = 0, m_va_st = 0, m_rm_st = 0;

  function automatic int cnt_same(logic [5:0] c);
    int n = 0;
    for (int i = 0; i < 10; i++) if (m_hv[i] && m_hc[i] == c) n++;
    return n;
  endfunction

  function automatic int cnt_diff(logic [5:0] c);
    int n = 0;
    for (int i = 0; i < 10; i++) if (m_hv[i] && m_hc[i] != c) n++;
    return n;
  endfunction

  function automatic logic [3:0] m_reg();
    return {m_rm_en, m_rm_st, m_va_en, m_va_st};
  endfunction

  task automatic model_step(logic v, logic [5:0] c, logic rd, logic wr,
                            logic [3:0] wd, logic md);
    logic ev_va = 0, ev_rm = 0;
    if (md && v) begin
      for (int i = 9; i > 0; i--) begin
        m_hc[i] = m_hc[i-1];
        m_hv[i] = m_hv[i-1];
      end
      m_hc[0] = c;
      m_hv[0] = 1'b1;
      if (!m_vld) begin
        for (int i = 0; i < 10; i++)
          if (!ev_va && m_hv[i] && cnt_same(m_hc[i]) >= 8) begin
            ev_va = 1;
            m_code = m_hc[i];
          end
        if (ev_va) m_vld = 1;
      end else if (cnt_diff(m_code) >= 3) begin
        ev_rm = 1;
        m_vld = 0;
      end
    end
    m_va_st = (m_va_st & ~rd) | ev_va;
    m_rm_st = (m_rm_st & ~rd) | ev_rm;
    if (wr) begin
      m_va_en = wd[1];
      m_rm_en = wd[3];
    end
  endtask

  task automatic chk(logic [7:0] got, logic [7:0] exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({7'd0, code_valid_o}, {7'd0, m_vld}, "R2 R3 code_valid_o");
    if (m_vld) chk({2'd0, code_o}, {2'd0, m_code}, "R2 code_o");
    chk({4'd0, reg_rdata_o}, {4'd0, m_reg()}, "R6 R10 reg_rdata_o");
    chk({7'd0, irq_o}, {7'd0, (m_rm_en & m_rm_st) | (m_va_en & m_va_st)}, "R8 irq_o");
  endtask

  // inputs change at the falling edge; results are compared one edge later
  task automatic cyc(logic v, logic [5:0] c, logic rd, logic wr,
                     logic [3:0] wd, logic md);
    msg_valid_i = v; msg_code_i = c; reg_rd_i = rd;
    reg_wr_i = wr; reg_wdata_i = wd; mode_cbit_i = md;
    @(posedge clk_i);
    model_step(v, c, rd, wr, wd, md);
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic send(logic [5:0] c);
    cyc(1, c, 0, 0, 4'h0, 1);
  endtask

  initial begin
    for (int i = 0; i < 10; i++) begin m_hc[i] = 0; m_hv[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk({7'd0, code_valid_o}, 8'd0, "R1 reset code_valid_o");
    chk({2'd0, code_o}, 8'd0, "R1 reset code_o");
    chk({4'd0, reg_rdata_o}, 8'd0, "R1 reset reg_rdata_o");
    chk({7'd0, irq_o}, 8'd0, "R1 reset irq_o");
    rst_ni = 1'b1;
    @(negedge clk_i);

    cyc(0, 0, 0, 1, 4'b1111, 1);
    chk({4'd0, reg_rdata_o}, 8'b1010, "R10 write loads enables only");

    for (int k = 0; k < 7; k++) send(6'h2A);
    chk({7'd0, code_valid_o}, 8'd0, "R2 R1 seven copies not enough");
    send(6'h2A);
    chk({7'd0, code_valid_o}, 8'd1, "R2 eighth copy validates");
    chk({2'd0, code_o}, 8'h2A, "R2 validated code");
    chk({4'd0, reg_rdata_o}, 8'b1011, "R4 validate pending set");
    chk({7'd0, irq_o}, 8'd1, "R8 irq on validate");

    cyc(0, 0, 1, 0, 4'h0, 1);
    chk({4'd0, reg_rdata_o}, 8'b1010, "R6 read clears pending");
    chk({7'd0, irq_o}, 8'd0, "R6 R8 irq drops after read");

    send(6'h05);
    send(6'h05);
    chk({7'd0, code_valid_o}, 8'd1, "R3 two differing keep code");
    send(6'h05);
    chk({7'd0, code_valid_o}, 8'd0, "R3 third differing removes");
    chk({4'd0, reg_rdata_o}, 8'b1110, "R5 remove pending set");

    for (int k = 0; k < 10; k++) cyc(1, 6'h11, 0, 0, 4'h0, 0);
    chk({7'd0, code_valid_o}, 8'd0, "R9 mode off no validation");
    chk({4'd0, reg_rdata_o}, 8'b1110, "R9 mode off flags unchanged");

    for (int k = 0; k < 4; k++) send(6'h05);
    chk({7'd0, code_valid_o}, 8'd0, "R11 four more copies not enough");
    cyc(1, 6'h05, 1, 0, 4'h0, 1);
    chk({7'd0, code_valid_o}, 8'd1, "R11 window kept after removal");
    chk({2'd0, code_o}, 8'h05, "R11 revalidated code");
    chk({4'd0, reg_rdata_o}, 8'b1011, "R7 event beats concurrent read");

    cyc(0, 0, 0, 1, 4'b0101, 1);
    chk({4'd0, reg_rdata_o}, 8'b0001, "R10 pending bits not writable");
    chk({7'd0, irq_o}, 8'd0, "R8 disabled pending masked");

    void'($urandom(32'd4711));
    for (int ph = 0; ph < 30; ph++) begin
      int bias = (ph % 2 == 0) ? 95 : 5;
      logic md = ($urandom_range(0, 9) != 0);
      for (int k = 0; k < 100; k++) begin
        logic v  = $urandom_range(0, 1);
        logic [5:0] c = ($urandom_range(0, 99) < bias) ? 6'h15 : 6'h2A;
        logic rd = ($urandom_range(0, 9) == 0);
        logic wr = ($urandom_range(0, 19) == 0);
        logic [3:0] wd = 4'($urandom());
        if ($urandom_range(0, 49) == 0) c = 6'($urandom());
        cyc(v, c, rd, wr, wd, md);
      end
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule